// File: doc/BRIEF.md
# Edge-Counting Scanline Timer Interrupt

This block is a programmable down-counter that requests an interrupt once a chosen number of events has been seen on one of two video timing inputs. The first is a video address line that toggles as rendering fetches move between pattern halves. The second is the horizontal sync pulse. Software picks the source, writes a count value, and then starts the counter with a separate strobe. Two more strobes turn the interrupt request on and off.

Both event inputs are asynchronous to the block clock, so each one passes through a synchronizer before it reaches its own edge detector. The counter only counts falling transitions. When the count runs out, a pending flag is set and the counter stops until software loads it again. The interrupt line is a level signal: it is high while the pending flag is set and the interrupt is enabled.

Top module: `scanline_event_timer`

## Requirements
- R1: After reset, irq is low, running is low, count is 0, the address-line source is selected and the interrupt is disabled.
- R2: A pulse on wr_preload stores cpu_wdata as the count value. A later wr_load pulse copies that stored value to the count output on the next clock.
- R3: While running, each counted event lowers count by exactly one.
- R4: A wr_src pulse takes cpu_wdata bit 0 as the source select. 0 selects addr_line and 1 selects hsync. Edges on the input that is not selected have no effect on count.
- R5: Only high-to-low transitions are counted. A low-to-high transition leaves count unchanged.
- R6: When count reaches 0, the pending flag is set and running falls. Further edges leave count at 0 and pending set until the next load.
- R7: irq is high exactly when the pending flag is set and the interrupt is enabled. A wr_irq_on pulse enables the interrupt, and this can raise irq for a flag that is already pending.
- R8: A wr_irq_off pulse disables the interrupt and clears the pending flag. If wr_irq_on and wr_irq_off arrive in the same cycle, the result is disabled.
- R9: A load with a stored value of 0 does not start the counter. It sets the pending flag on the next clock instead.
- R10: A load while the counter is running, or while a flag is pending, restarts from the stored value and clears the pending flag.
- R11: A falling edge on the selected input changes count on the (SYNC_STAGES+1)-th rising clock edge after the input falls. With the default of two stages, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wdata | input | DATA_W | Write data shared by all strobes |
| wr_preload | input | 1 | Store cpu_wdata as the count value |
| wr_load | input | 1 | Copy the stored value into the counter and start it |
| wr_irq_off | input | 1 | Disable the interrupt and clear the pending flag |
| wr_irq_on | input | 1 | Enable the interrupt |
| wr_src | input | 1 | Take cpu_wdata bit 0 as the source select |
| addr_line | input | 1 | Video address line event input (asynchronous) |
| hsync | input | 1 | Horizontal sync event input (asynchronous) |
| irq | output | 1 | Level interrupt request |
| running | output | 1 | Counter is active |
| count | output | DATA_W | Current counter value |

## Verification
A wrong internal state shows up at the count output on the clock edge where it goes wrong. Examples are a missed decrement, an edge taken from the wrong input, or a rising edge that is counted. An edge-detector or synchronizer fault moves the change in count away from the third rising edge after the input falls. A stuck pending or enable flag shows on irq in the cycle after the strobe that should have changed it. The bench therefore samples count and irq at fixed cycle offsets after each stimulus, instead of waiting loosely for the result.

// File: rtl/scanline_event_timer.sv
module scanline_event_timer #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              wr_preload,
  input  logic              wr_load,
  input  logic              wr_irq_off,
  input  logic              wr_irq_on,
  input  logic              wr_src,
  input  logic              addr_line,
  input  logic              hsync,
  output logic              irq,
  output logic              running,
  output logic [DATA_W-1:0] count
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [SYNC_STAGES-1:0] a_sr, h_sr;
  logic                   a_prev, h_prev;
  logic                   a_fall, h_fall, ev;
  logic [DATA_W-1:0]      preload_q, cnt_q;
  logic                   run_q, pend_q, en_q, src_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sr   <= '0;
      h_sr   <= '0;
      a_prev <= 1'b0;
      h_prev <= 1'b0;
    end else begin
      a_sr   <= (a_sr << 1) | SYNC_STAGES'(addr_line);
      h_sr   <= (h_sr << 1) | SYNC_STAGES'(hsync);
      a_prev <= a_sr[SYNC_STAGES-1];
      h_prev <= h_sr[SYNC_STAGES-1];
    end

  assign a_fall = a_prev & ~a_sr[SYNC_STAGES-1];
  assign h_fall = h_prev & ~h_sr[SYNC_STAGES-1];
  assign ev     = src_q ? h_fall : a_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      preload_q <= ZERO;
      cnt_q     <= ZERO;
      run_q     <= 1'b0;
      pend_q    <= 1'b0;
      en_q      <= 1'b0;
      src_q     <= 1'b0;
    end else begin
      if (wr_preload) preload_q <= cpu_wdata;
      if (wr_src)     src_q     <= cpu_wdata[0];
      if (wr_irq_off)     en_q <= 1'b0;
      else if (wr_irq_on) en_q <= 1'b1;
      if (wr_load) begin
        cnt_q  <= preload_q;
        run_q  <= (preload_q != ZERO);
        pend_q <= (preload_q == ZERO);
      end else if (run_q && ev) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          run_q  <= 1'b0;
          pend_q <= 1'b1;
        end
      end
      if (wr_irq_off) pend_q <= 1'b0;
    end

  assign irq     = pend_q & en_q;
  assign running = run_q;
  assign count   = cnt_q;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> cnt_q == $past(preload_q)); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && ev && !wr_load |=> cnt_q == $past(cnt_q) - ONE); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !wr_load |=> $stable(cnt_q)); // R6
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_load) || $past(run_q && cnt_q == ONE)); // R6
  AST_OFF_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_off |=> !irq && !pend_q); // R8
  AST_ON_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_on && !wr_irq_off && pend_q && !wr_load |=> irq); // R7
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load && preload_q == ZERO && !wr_irq_off |=> pend_q && !run_q); // R9
endmodule

// File: tb/scanline_event_timer_test.sv
module scanline_event_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       wr_preload = 0, wr_load = 0, wr_irq_off = 0, wr_irq_on = 0, wr_src = 0;
  logic       addr_line = 0, hsync = 0;
  logic       irq, running;
  logic [7:0] count;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  scanline_event_timer uut (
    .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata),
    .wr_preload(wr_preload), .wr_load(wr_load), .wr_irq_off(wr_irq_off),
    .wr_irq_on(wr_irq_on), .wr_src(wr_src), .addr_line(addr_line),
    .hsync(hsync), .irq(irq), .running(running), .count(count));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(int which, logic [7:0] d);
    cpu_wdata = d;
    case (which)
      0: wr_preload = 1;
      1: wr_load = 1;
      2: wr_irq_off = 1;
      3: wr_irq_on = 1;
      default: wr_src = 1;
    endcase
    @(negedge clk);
    {wr_preload, wr_load, wr_irq_off, wr_irq_on, wr_src} = '0;
  endtask

  task automatic fall_addr();
    addr_line = 1; idle(5);
    addr_line = 0; idle(5);
  endtask

  task automatic fall_hsync();
    hsync = 1; idle(5);
    hsync = 0; idle(5);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 running", running, 0);
    chk("R1 count", count, 0);
  endtask

  task automatic t_basic();
    strobe(4, 8'h00);
    strobe(0, 8'd3);
    strobe(3, 8'h00);
    strobe(1, 8'h00);
    chk("R2 count after load", count, 3);
    chk("R3 running", running, 1);
    fall_addr();
    chk("R3 count", count, 2);
    fall_addr();
    chk("R3 count", count, 1);
    chk("R7 irq before end", irq, 0);
    fall_addr();
    chk("R6 count zero", count, 0);
    chk("R6 stopped", running, 0);
    chk("R7 irq", irq, 1);
    fall_addr();
    chk("R6 held at zero", count, 0);
    chk("R6 still pending", irq, 1);
  endtask

  task automatic t_source();
    strobe(2, 8'h00);
    chk("R8 irq off", irq, 0);
    strobe(4, 8'h01);
    strobe(0, 8'd2);
    strobe(1, 8'h00);
    fall_addr();
    chk("R4 unselected ignored", count, 2);
    fall_hsync();
    chk("R4 hsync counted", count, 1);
    hsync = 1; idle(6);
    chk("R5 rise ignored", count, 1);
    hsync = 0; idle(6);
    chk("R5 fall counted", count, 0);
    chk("R7 pending but disabled", irq, 0);
    strobe(3, 8'h00);
    chk("R7 enable raises irq", irq, 1);
  endtask

  task automatic t_off();
    strobe(2, 8'h00);
    strobe(3, 8'h00);
    chk("R8 pending cleared", irq, 0);
    strobe(0, 8'd0);
    strobe(1, 8'h00);
    chk("R9 zero load pends", irq, 1);
    chk("R9 not running", running, 0);
    cpu_wdata = 0; wr_irq_on = 1; wr_irq_off = 1;
    @(negedge clk);
    {wr_irq_on, wr_irq_off} = '0;
    chk("R8 off wins", irq, 0);
    strobe(1, 8'h00);
    chk("R8 still disabled", irq, 0);
  endtask

  task automatic t_reload();
    strobe(3, 8'h00);
    strobe(0, 8'd2);
    strobe(1, 8'h00);
    chk("R10 pending cleared", irq, 0);
    chk("R10 count", count, 2);
    strobe(4, 8'h00);
    strobe(0, 8'd4);
    strobe(1, 8'h00);
    fall_addr();
    chk("R10 count before reload", count, 3);
    strobe(1, 8'h00);
    chk("R10 restarted", count, 4);
  endtask

  task automatic t_latency();
    addr_line = 1; idle(5);
    addr_line = 0;
    idle(2);
    chk("R11 unchanged after two edges", count, 4);
    idle(1);
    chk("R11 changed on third edge", count, 3);
    idle(3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_basic();
    t_source();
    t_off();
    t_reload();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule